// File: doc/BRIEF.md
# Four-Plane Graphics Write/Read Datapath

This block sits between a byte-wide processor data path and four parallel 8-bit memory planes. One processor byte address reaches the same byte in all four planes at once. A read copies all four plane bytes into a 32-bit latch and returns one of them to the processor. A write does not store the processor byte directly. For each plane, the stored byte is built from the processor byte or a replicated colour bit, the latch, a logical function and a per-bit mask.

The processor configures the block through a small register file with nine 8-bit entries. Software first writes a register number to the index port, then reads or writes that register through the data port. A 16-bit write to the index port sets the index and the register value in one access. The path from processor write data to plane write data is combinational, so the plane write enables and data appear in the same cycle as the processor's write strobe.

Top module: `gfx_plane_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the index and all nine registers read 0x00, and the latch holds zero.
- R2: An 8-bit write to the index port (`io_sel`=0) stores the register number. A write to the data port (`io_sel`=1) updates the selected register. A read of the data port returns the selected register, and a read of the index port returns the stored index.
- R3: A 16-bit write to the index port (`io_wide`=1) stores `io_wdata[7:0]` as the index and `io_wdata[15:8]` into that register in the same cycle.
- R4: Writes to a register number above 8 leave every register unchanged. Data-port reads at such an index return 0x00.
- R5: A memory read loads all four plane bytes into the latch at the next clock edge. `cpu_rdata` returns plane byte n, where n is bits 1:0 of register 4. Plane n occupies bits 8n+7:8n of the plane buses.
- R6: During a write, a plane whose bit in register 1 is 1 takes its bit of register 0, copied across all 8 bits, as its operand.
- R7: A plane whose bit in register 1 is 0 takes the processor byte rotated right by bits 2:0 of register 3.
- R8: Bits 4:3 of register 3 combine the operand with that plane's latch byte: 00 passes the operand, 01 ANDs, 10 ORs and 11 XORs.
- R9: A bit set to 1 in register 8 takes the combined result. A bit set to 0 keeps the latch bit for that plane.
- R10: `plane_we` is 4'hF in every cycle with `mem_wr` high and 4'h0 otherwise, in the same cycle as `plane_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_wr | input | 1 | Register-port write strobe |
| io_rd | input | 1 | Register-port read strobe |
| io_sel | input | 1 | 0 = index port, 1 = data port |
| io_wide | input | 1 | 16-bit write to the index port |
| io_wdata | input | 16 | Register-port write data |
| io_rdata | output | 8 | Register-port read data (0 when not reading) |
| mem_rd | input | 1 | Processor memory read |
| mem_wr | input | 1 | Processor memory write |
| cpu_wdata | input | 8 | Processor write byte |
| cpu_rdata | output | 8 | Selected plane byte |
| plane_rdata | input | 32 | Bytes read from the four planes |
| plane_wdata | output | 32 | Bytes to write to the four planes |
| plane_we | output | 4 | Per-plane write enables |

## Verification
On every cycle the assertions check four things. The write enables follow the write strobe. Mask bits at zero reproduce the latch. The latch captures the plane bytes after each read. Out-of-range data-port reads return zero. Other behaviour can only be shown by the bench's scenarios, because each result depends on a sequence of register programming, a latch load and a write. This covers the choice between colour substitution and rotated data, the rotate amount, the four logical functions, the selection of the read plane and the combined index-and-data access.

// File: rtl/gfx_pkg.sv
// Shared constants for the four-plane graphics datapath.
// Assumes that register numbers fit in one byte and that there are at most 16 registers.
package gfx_pkg;
    localparam int DW     = 8;
    localparam int PLANES = 4;
    localparam int NREGS  = 9;
    localparam int SELW   = $clog2(NREGS);
    localparam int ROTW   = $clog2(DW);
    localparam int MAPW   = $clog2(PLANES);

    localparam int IDX_SETRES = 0;
    localparam int IDX_ENSR   = 1;
    localparam int IDX_ROTFN  = 3;
    localparam int IDX_RDMAP  = 4;
    localparam int IDX_MASK   = 8;

    typedef enum logic [1:0] {
        FN_COPY = 2'b00,
        FN_AND  = 2'b01,
        FN_OR   = 2'b10,
        FN_XOR  = 2'b11
    } alu_fn_e;
endpackage

// File: rtl/gfx_regfile.sv
// Indexed configuration registers: an index port and a data port, plus a combined 16-bit index+data write.
// Assumes that writes above the last index are dropped and that reads there return zero.
module gfx_regfile
    import gfx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic              io_sel,
    input  logic              io_wide,
    input  logic [2*DW-1:0]   io_wdata,
    output logic [DW-1:0]     io_rdata,
    output logic [PLANES-1:0] setres,
    output logic [PLANES-1:0] ensr,
    output logic [ROTW-1:0]   rot_cnt,
    output alu_fn_e           alu_fn,
    output logic [MAPW-1:0]   rd_map,
    output logic [DW-1:0]     bit_mask
);
    logic [DW-1:0] idx_q;
    logic [DW-1:0] regs_q [NREGS];
    logic          wide_wr, data_wr, wr_en;
    logic [DW-1:0] wr_idx, wr_val, rd_val;
    logic          wr_in_range, rd_in_range;

    // Choose the target register and value for this cycle's write.
    always_comb begin
        wide_wr     = io_wr && !io_sel && io_wide;
        data_wr     = io_wr && io_sel;
        wr_en       = wide_wr || data_wr;
        wr_idx      = wide_wr ? io_wdata[DW-1:0] : idx_q;
        wr_val      = wide_wr ? io_wdata[2*DW-1:DW] : io_wdata[DW-1:0];
        wr_in_range = (wr_idx < DW'(NREGS));
        rd_in_range = (idx_q < DW'(NREGS));
    end

    // Hold the current index.
    always_ff @(posedge clk) begin
        if (!rst_n)                idx_q <= '0;
        else if (io_wr && !io_sel) idx_q <= io_wdata[DW-1:0];
    end

    // Update the register array.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) regs_q[i] <= '0;
        end else if (wr_en && wr_in_range) begin
            regs_q[wr_idx[SELW-1:0]] <= wr_val;
        end
    end

    // Read multiplexer for both ports.
    always_comb begin
        if (!io_sel)          rd_val = idx_q;
        else if (rd_in_range) rd_val = regs_q[idx_q[SELW-1:0]];
        else                  rd_val = '0;
        io_rdata = io_rd ? rd_val : '0;
    end

    // Decode the fields used by the datapath.
    always_comb begin
        setres   = regs_q[IDX_SETRES][PLANES-1:0];
        ensr     = regs_q[IDX_ENSR][PLANES-1:0];
        rot_cnt  = regs_q[IDX_ROTFN][ROTW-1:0];
        alu_fn   = alu_fn_e'(regs_q[IDX_ROTFN][ROTW+1:ROTW]);
        rd_map   = regs_q[IDX_RDMAP][MAPW-1:0];
        bit_mask = regs_q[IDX_MASK];
    end
endmodule

// File: rtl/gfx_latch.sv
// Read latch: captures all plane bytes on each memory read and returns the selected plane's byte.
// Assumes that plane_rdata is valid in the same cycle as mem_rd.
module gfx_latch
    import gfx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mem_rd,
    input  logic [PLANES*DW-1:0] plane_rdata,
    input  logic [MAPW-1:0]      rd_map,
    output logic [PLANES*DW-1:0] latch_q,
    output logic [DW-1:0]        cpu_rdata
);
    // Capture the full plane word on a read.
    always_ff @(posedge clk) begin
        if (!rst_n)      latch_q <= '0;
        else if (mem_rd) latch_q <= plane_rdata;
    end

    // Return the chosen plane's byte.
    always_comb cpu_rdata = plane_rdata[rd_map*DW +: DW];
endmodule

// File: rtl/gfx_write_unit.sv
// Write-mode-0 path, one copy per plane: substitute or rotate, combine with the latch, then mask.
// Assumes a purely combinational path, so the result is valid in the cycle of the write.
module gfx_write_unit
    import gfx_pkg::*;
(
    input  logic [DW-1:0]        cpu_wdata,
    input  logic [PLANES-1:0]    setres,
    input  logic [PLANES-1:0]    ensr,
    input  logic [ROTW-1:0]      rot_cnt,
    input  alu_fn_e              alu_fn,
    input  logic [DW-1:0]        bit_mask,
    input  logic [PLANES*DW-1:0] latch_q,
    output logic [PLANES*DW-1:0] plane_wdata
);
    logic [DW-1:0]   rotated;
    logic [2*DW-1:0] dbl;

    // Rotate the processor byte right.
    always_comb begin
        dbl     = {cpu_wdata, cpu_wdata} >> rot_cnt;
        rotated = dbl[DW-1:0];
    end

    for (genvar p = 0; p < PLANES; p++) begin : g_plane
        logic [DW-1:0] opnd, lat, res;
        // Per-plane operand, logical function and mask merge.
        always_comb begin
            lat  = latch_q[p*DW +: DW];
            opnd = ensr[p] ? {DW{setres[p]}} : rotated;
            unique case (alu_fn)
                FN_COPY: res = opnd;
                FN_AND:  res = opnd & lat;
                FN_OR:   res = opnd | lat;
                default: res = opnd ^ lat;
            endcase
            plane_wdata[p*DW +: DW] = (res & bit_mask) | (lat & ~bit_mask);
        end
    end
endmodule

// File: rtl/gfx_plane_ctrl.sv
// Top of the four-plane graphics datapath: register file, read latch and per-plane write path.
// Assumes that mem_rd and mem_wr are not asserted together. A write then uses the latch as it stood before the cycle.
module gfx_plane_ctrl
    import gfx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 io_wr,
    input  logic                 io_rd,
    input  logic                 io_sel,
    input  logic                 io_wide,
    input  logic [2*DW-1:0]      io_wdata,
    output logic [DW-1:0]        io_rdata,
    input  logic                 mem_rd,
    input  logic                 mem_wr,
    input  logic [DW-1:0]        cpu_wdata,
    output logic [DW-1:0]        cpu_rdata,
    input  logic [PLANES*DW-1:0] plane_rdata,
    output logic [PLANES*DW-1:0] plane_wdata,
    output logic [PLANES-1:0]    plane_we
);
    logic [PLANES-1:0]    setres, ensr;
    logic [ROTW-1:0]      rot_cnt;
    alu_fn_e              alu_fn;
    logic [MAPW-1:0]      rd_map;
    logic [DW-1:0]        bit_mask;
    logic [PLANES*DW-1:0] latch_q;

    gfx_regfile u_regs (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd), .io_sel(io_sel),
        .io_wide(io_wide), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .setres(setres), .ensr(ensr), .rot_cnt(rot_cnt), .alu_fn(alu_fn),
        .rd_map(rd_map), .bit_mask(bit_mask)
    );

    gfx_latch u_latch (
        .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .plane_rdata(plane_rdata),
        .rd_map(rd_map), .latch_q(latch_q), .cpu_rdata(cpu_rdata)
    );

    gfx_write_unit u_wr (
        .cpu_wdata(cpu_wdata), .setres(setres), .ensr(ensr), .rot_cnt(rot_cnt),
        .alu_fn(alu_fn), .bit_mask(bit_mask), .latch_q(latch_q), .plane_wdata(plane_wdata)
    );

    // All planes are written together, in the same cycle as the strobe.
    always_comb plane_we = {PLANES{mem_wr}};
endmodule

// File: rtl/gfx_plane_ctrl_chk.sv
// Assertion checker for gfx_plane_ctrl, attached with bind. It observes ports plus the latch and the mask.
module gfx_plane_ctrl_chk
    import gfx_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 io_rd,
    input logic                 io_sel,
    input logic [DW-1:0]        io_rdata,
    input logic                 mem_rd,
    input logic                 mem_wr,
    input logic [PLANES*DW-1:0] plane_rdata,
    input logic [PLANES*DW-1:0] plane_wdata,
    input logic [PLANES-1:0]    plane_we,
    input logic [PLANES*DW-1:0] latch_q,
    input logic [DW-1:0]        bit_mask,
    input logic [DW-1:0]        cur_idx
);
    // R10: write enables follow the write strobe.
    p_we_on_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> plane_we == {PLANES{1'b1}});
    p_we_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_wr |-> plane_we == '0);

    // R5: the latch captures the plane word after a read.
    p_latch_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> latch_q == $past(plane_rdata));

    // R1: reset clears the latch.
    p_reset_latch_r1: assert property (@(posedge clk)
        !rst_n |=> latch_q == '0);

    // R4: out-of-range data-port reads return zero.
    p_oor_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && io_sel && cur_idx >= DW'(NREGS)) |-> io_rdata == '0);

    // R9: masked-off bits reproduce the latch in every plane.
    for (genvar p = 0; p < PLANES; p++) begin : g_mask
        p_mask_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
            mem_wr |-> ((plane_wdata[p*DW +: DW] ^ latch_q[p*DW +: DW]) & ~bit_mask) == '0);
    end
endmodule

bind gfx_plane_ctrl gfx_plane_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .io_rd(io_rd), .io_sel(io_sel), .io_rdata(io_rdata),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .plane_rdata(plane_rdata), .plane_wdata(plane_wdata),
    .plane_we(plane_we), .latch_q(latch_q), .bit_mask(bit_mask), .cur_idx(u_regs.idx_q)
);

// File: tb/sim_gfx_plane_ctrl.sv
module sim_gfx_plane_ctrl;
    logic        clk = 0, rst_n = 0;
    logic        io_wr = 0, io_rd = 0, io_sel = 0, io_wide = 0;
    logic [15:0] io_wdata = 0;
    logic [7:0]  io_rdata;
    logic        mem_rd = 0, mem_wr = 0;
    logic [7:0]  cpu_wdata = 0, cpu_rdata;
    logic [31:0] plane_rdata = 0, plane_wdata;
    logic [3:0]  plane_we;
    int          nchk = 0, nfail = 0;
    logic        done = 0;

    always #5 clk = ~clk;

    gfx_plane_ctrl u0 (.*);

    // {setres, ensr, rotfn, mask, latch, cpu, expected}
    localparam logic [95:0] VEC [9] = '{
        {4'h0, 4'h0, 8'h00, 8'hFF, 32'h00000000, 8'hA5, 32'hA5A5A5A5}, // R8 copy
        {4'h0, 4'h0, 8'h01, 8'hFF, 32'h00000000, 8'h03, 32'h81818181}, // R7 rotate 1
        {4'h1, 4'h5, 8'h00, 8'hFF, 32'h00000000, 8'h3C, 32'h3C003CFF}, // R6 substitution
        {4'h0, 4'h0, 8'h08, 8'hFF, 32'hF0F0F0F0, 8'h3C, 32'h30303030}, // R8 AND
        {4'h0, 4'h0, 8'h10, 8'hFF, 32'h0F0F0F0F, 8'h30, 32'h3F3F3F3F}, // R8 OR
        {4'h0, 4'h0, 8'h18, 8'hFF, 32'hFF00FF00, 8'h0F, 32'hF00FF00F}, // R8 XOR
        {4'h0, 4'h0, 8'h00, 8'h0F, 32'h12345678, 8'hAB, 32'h1B3B5B7B}, // R9 mask
        {4'hA, 4'hF, 8'h1C, 8'hFF, 32'h0000FFFF, 8'h55, 32'hFF0000FF}, // R6 R8 all substituted, XOR
        {4'h0, 4'h0, 8'h07, 8'hFF, 32'h00000000, 8'h01, 32'h02020202}  // R7 rotate 7
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic io_write(input logic sel, input logic wide, input logic [15:0] d);
        @(negedge clk); io_wr = 1; io_sel = sel; io_wide = wide; io_wdata = d;
        @(negedge clk); io_wr = 0; io_wide = 0;
    endtask

    task automatic io_read(input logic sel, output logic [7:0] d);
        @(negedge clk); io_rd = 1; io_sel = sel;
        #1 d = io_rdata;
        @(negedge clk); io_rd = 0;
    endtask

    task automatic set_reg(input logic [7:0] idx, input logic [7:0] val);
        io_write(0, 1, {val, idx});
    endtask

    task automatic load_latch(input logic [31:0] w);
        @(negedge clk); mem_rd = 1; plane_rdata = w;
        @(negedge clk); mem_rd = 0;
    endtask

    task automatic mem_write(input logic [7:0] b, output logic [31:0] wd, output logic [3:0] we);
        @(negedge clk); mem_wr = 1; cpu_wdata = b;
        #1 wd = plane_wdata; we = plane_we;
        @(negedge clk); mem_wr = 0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin : main
        logic [7:0]  rd;
        logic [31:0] wd;
        logic [3:0]  we;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: reset state of the index and of every register.
        io_read(0, rd); check("R1 index", {24'h0, rd}, 32'h0);
        for (int i = 0; i < 9; i++) begin
            io_write(0, 0, 16'(i));
            io_read(1, rd); check("R1 reg", {24'h0, rd}, 32'h0);
        end
        io_write(0, 0, 16'h0008);
        mem_write(8'hFF, wd, we); check("R1 latch zero via mask 0", wd, 32'h0);

        // Table walk: R6 R7 R8 R9 R10.
        for (int v = 0; v < 9; v++) begin
            set_reg(8'd0, {4'h0, VEC[v][95:92]});
            set_reg(8'd1, {4'h0, VEC[v][91:88]});
            set_reg(8'd3, VEC[v][87:80]);
            set_reg(8'd8, VEC[v][79:72]);
            load_latch(VEC[v][71:40]);
            mem_write(VEC[v][39:32], wd, we);
            check("R6-9 vector", wd, VEC[v][31:0]);
            check("R10 we", {28'h0, we}, 32'hF);
        end
        #1 check("R10 idle we", {28'h0, plane_we}, 32'h0);

        // R2: byte index write, byte data write and read-back.
        io_write(0, 0, 16'h0002);
        io_write(1, 0, 16'h00C3);
        io_read(1, rd); check("R2 data", {24'h0, rd}, 32'hC3);
        io_read(0, rd); check("R2 index", {24'h0, rd}, 32'h02);

        // R3: combined write; a 16-bit write also changes the index.
        io_write(0, 1, 16'h7E07);
        io_read(0, rd); check("R3 index", {24'h0, rd}, 32'h07);
        io_read(1, rd); check("R3 data", {24'h0, rd}, 32'h7E);

        // R4: out-of-range write dropped, read is zero, neighbours untouched.
        io_write(0, 1, 16'h5509);
        io_read(1, rd); check("R4 read 9", {24'h0, rd}, 32'h0);
        io_write(0, 0, 16'h000F);
        io_write(1, 0, 16'h00AA);
        io_read(1, rd); check("R4 read F", {24'h0, rd}, 32'h0);
        for (int i = 0; i < 9; i++) begin
            if (i == 2 || i == 7) continue;
            io_write(0, 0, 16'(i));
            io_read(1, rd);
            check("R4 untouched", {24'h0, rd}, (i == 8) ? 32'hFF : (i == 3) ? 32'h07 : 32'h0);
        end

        // R5: read plane select and latch load.
        for (int m = 0; m < 4; m++) begin
            set_reg(8'd4, 8'(m));
            @(negedge clk); mem_rd = 1; plane_rdata = 32'h44332211;
            #1 check("R5 rdata", {24'h0, cpu_rdata}, 32'((m + 1) * 8'h11));
            @(negedge clk); mem_rd = 0;
        end
        set_reg(8'd1, 8'h00); set_reg(8'd3, 8'h00); set_reg(8'd8, 8'h00);
        mem_write(8'h00, wd, we); check("R5 latch", wd, 32'h44332211);

        // R1: reset in the middle of a run clears registers.
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        io_write(0, 0, 16'h0004);
        io_read(1, rd); check("R1 rereset", {24'h0, rd}, 32'h0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule